// File: doc/BRIEF.md
# Header CRC Fault Monitor for Router Outputs

This block sits on the output side of a mesh router and watches the flit stream leaving each output port. Every packet header carries a 4-bit check value over the rest of the header word. The monitor recomputes that value as the header passes through, compares it with the received field and raises an error pulse on any mismatch. The pulse covers corruption that the input buffer, the crossbar or the link added on the way. The check only detects errors. It never repairs a flit.

Each detected fault is stored in a small fault table of 3-bit status words. The table has one word per output port and one for the router as a whole. A fault blamed on the link marks that port as unsafe. A fault blamed on a router-internal component marks the whole router as unsafe. The table feeds the local next-port selection and the neighbouring routers of the same subnet. Entries stay set until a clear request or a reset.

Top module: `fdm_crc_fault_monitor`

## Requirements
- R1: On a flit with valid and header set, the low 4 bits of the 16-bit flit are the received check value and the high 12 bits are covered. The check is computed bit-serially over the covered bits, MSB first, from an all-zero start, with generator 1 + x + x^4. When it differs from the received value, that port's `err_pulse` bit is high in the cycle after the sampling edge, for that one cycle only.
- R2: A header whose check value matches produces no pulse and changes no status entry.
- R3: A valid flit with the header bit clear (a body or tail flit) is never checked. It raises no pulse and changes no status, whatever its low bits hold.
- R4: A header flit is a framing fault, and pulses whatever its check value, if it arrives on a port where an earlier header without the tail bit has not yet been closed by a tail flit. A header opens a packet unless its own tail bit is set. A tail flit closes the packet.
- R5: `fault_status` holds four 3-bit entries. Entry i sits at bits [3i+2:3i] and reads {unsafe, i[1:0]}. Index 00 is the east port (port 0), 01 the north port (port 1), 10 the south port (port 2) and 11 the router. With nothing unsafe, the whole value is 12'h688.
- R6: A fault on port p with `comp_id` 00 (link) sets entry p unsafe. A fault with `comp_id` 01 (buffer), 10 (crossbar) or 11 (other internal) sets the router entry unsafe and leaves entry p as it was.
- R7: Unsafe entries stay set through any later traffic. A high `clr_flt` returns every entry to safe at the next edge, except an entry that a fault sets on that same edge: the set wins.
- R8: The status update becomes visible in the same cycle as the error pulse.
- R9: The ports are checked independently. Faults on several ports in the same cycle all pulse and are all recorded.
- R10: After reset, `err_pulse` is zero, every entry is safe and no packet is open on any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_flt | input | 1 | Return all fault entries to safe |
| flit_valid | input | 3 | Flit present, one bit per output port |
| flit_head | input | 3 | Header flit marker per port |
| flit_tail | input | 3 | Tail flit marker per port |
| flit_data | input | 48 | Flit words, port p at bits [16p+15:16p] |
| comp_id | input | 6 | Component blamed for a fault on port p, bits [2p+1:2p] |
| err_pulse | output | 3 | One-cycle check failure per port |
| fault_status | output | 12 | Four 3-bit safe/unsafe entries |

## Verification
A wrong check value or a broken framing tracker shows up one cycle after the offending header, as a pulse that is missing or that should not be there. A fault table that loses, leaks or misplaces a bit shows up in `fault_status` on that same cycle. Any error persists there because entries are sticky, so later safe traffic and clears expose it as well. A broken clear priority is visible only on the cycle where a fault and a clear coincide, so that case is driven on purpose.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
   // Component blamed for a detected fault
   typedef enum logic [1:0] {
      SRC_LINK  = 2'b00,
      SRC_BUF   = 2'b01,
      SRC_XBAR  = 2'b10,
      SRC_OTHER = 2'b11
   } fdm_src_e;

   localparam int unsigned FDM_SRC_W = 2;
endpackage

// File: rtl/fdm_crc_calc.sv
module fdm_crc_calc #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned CRC_W  = 4,
   parameter logic [CRC_W-1:0] POLY = 4'b0011
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);
   // Bit-serial division unrolled over the covered bits, MSB first, zero start
   always_comb begin
      logic [CRC_W-1:0] acc;
      logic             fb;
      acc = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb  = acc[CRC_W-1] ^ data_i[i];
         acc = {acc[CRC_W-2:0], 1'b0};
         if (fb) acc = acc ^ POLY;
      end
      crc_o = acc;
   end
endmodule

// File: rtl/fdm_port_check.sv
module fdm_port_check #(
   parameter int unsigned FLIT_W     = 16,
   parameter int unsigned CRC_W      = 4,
   parameter logic [CRC_W-1:0] POLY  = 4'b0011,
   parameter bit          CRC_AT_LSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              head_i,
   input  logic              tail_i,
   input  logic [FLIT_W-1:0] data_i,
   output logic              hit_o,
   output logic              err_o
);
   localparam int unsigned COV_W = FLIT_W - CRC_W;

   logic [COV_W-1:0] cover_bits;
   logic [CRC_W-1:0] rx_crc;
   logic [CRC_W-1:0] calc_crc;
   logic             mismatch;
   logic             framing;
   logic             in_pkt_q;
   logic             err_q;

   generate
      if (CRC_AT_LSB) begin : g_crc_low
         assign rx_crc     = data_i[CRC_W-1:0];
         assign cover_bits = data_i[FLIT_W-1:CRC_W];
      end else begin : g_crc_high
         assign rx_crc     = data_i[FLIT_W-1:COV_W];
         assign cover_bits = data_i[COV_W-1:0];
      end
   endgenerate

   fdm_crc_calc #(
      .DATA_W (COV_W),
      .CRC_W  (CRC_W),
      .POLY   (POLY)
   ) i_calc (
      .data_i (cover_bits),
      .crc_o  (calc_crc)
   );

   assign mismatch = calc_crc != rx_crc;
   assign framing  = in_pkt_q;
   assign hit_o    = valid_i && head_i && (mismatch || framing);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         err_q <= hit_o;
         if (valid_i) begin
            if (head_i)      in_pkt_q <= !tail_i;
            else if (tail_i) in_pkt_q <= 1'b0;
         end
      end
   end

   assign err_o = err_q;

   a_r1_pulse_after_header: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> $past(valid_i && head_i));
   a_r3_body_never_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !head_i) |=> !err_q);
   a_r4_tail_closes_packet: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && tail_i) |=> !in_pkt_q);
   a_r4_open_header_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && head_i && in_pkt_q) |=> err_q);
endmodule

// File: rtl/fdm_fault_reg.sv
module fdm_fault_reg #(
   parameter int unsigned NUM_ENT = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr_i,
   input  logic [NUM_ENT-1:0]            set_i,
   output logic [NUM_ENT*(IDX_W+1)-1:0]  status_o
);
   localparam int unsigned ENT_W = IDX_W + 1;

   logic [NUM_ENT-1:0] unsafe_q;

   generate
      for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          unsafe_q[e] <= 1'b0;
            else if (set_i[e])   unsafe_q[e] <= 1'b1;
            else if (clr_i)      unsafe_q[e] <= 1'b0;
         end

         assign status_o[e*ENT_W +: ENT_W] = {unsafe_q[e], IDX_W'(e)};

         a_r7_entry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (unsafe_q[e] && !clr_i) |=> unsafe_q[e]);
         a_r6_set_recorded: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[e] |=> unsafe_q[e]);
         a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[e]) |=> !unsafe_q[e]);
         a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!unsafe_q[e] && !set_i[e]) |=> !unsafe_q[e]);
      end
   endgenerate
endmodule

// File: rtl/fdm_crc_fault_monitor.sv
module fdm_crc_fault_monitor
   import fdm_pkg::*;
#(
   parameter int unsigned NUM_PORTS  = 3,
   parameter int unsigned FLIT_W     = 16,
   parameter int unsigned CRC_W      = 4,
   parameter logic [CRC_W-1:0] POLY  = 4'b0011,
   parameter bit          CRC_AT_LSB = 1'b1,
   localparam int unsigned NUM_ENT   = NUM_PORTS + 1,
   localparam int unsigned IDX_W     = $clog2(NUM_ENT),
   localparam int unsigned ENT_W     = IDX_W + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr_flt,
   input  logic [NUM_PORTS-1:0]          flit_valid,
   input  logic [NUM_PORTS-1:0]          flit_head,
   input  logic [NUM_PORTS-1:0]          flit_tail,
   input  logic [NUM_PORTS*FLIT_W-1:0]   flit_data,
   input  logic [NUM_PORTS*FDM_SRC_W-1:0] comp_id,
   output logic [NUM_PORTS-1:0]          err_pulse,
   output logic [NUM_ENT*ENT_W-1:0]      fault_status
);
   localparam int unsigned ROUTER_IDX = NUM_PORTS;

   // Elaboration-time parameter checks
   generate
      if (CRC_W < 2)           begin : g_bad_crc  $error("CRC_W must be at least 2"); end
      if (FLIT_W <= CRC_W)     begin : g_bad_flit $error("FLIT_W must exceed CRC_W"); end
      if (NUM_PORTS < 1)       begin : g_bad_port $error("NUM_PORTS must be positive"); end
   endgenerate

   logic [NUM_PORTS-1:0] hit;
   logic [NUM_PORTS-1:0] port_set;
   logic [NUM_PORTS-1:0] core_set;
   logic [NUM_ENT-1:0]   set_vec;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         fdm_src_e src;
         assign src = fdm_src_e'(comp_id[p*FDM_SRC_W +: FDM_SRC_W]);

         fdm_port_check #(
            .FLIT_W     (FLIT_W),
            .CRC_W      (CRC_W),
            .POLY       (POLY),
            .CRC_AT_LSB (CRC_AT_LSB)
         ) i_chk (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (flit_valid[p]),
            .head_i  (flit_head[p]),
            .tail_i  (flit_tail[p]),
            .data_i  (flit_data[p*FLIT_W +: FLIT_W]),
            .hit_o   (hit[p]),
            .err_o   (err_pulse[p])
         );

         assign port_set[p] = hit[p] && (src == SRC_LINK);
         assign core_set[p] = hit[p] && (src != SRC_LINK);

         a_r8_pulse_with_status: assert property (@(posedge clk) disable iff (!rst_n)
            err_pulse[p] |-> (fault_status[p*ENT_W + IDX_W] ||
                              fault_status[ROUTER_IDX*ENT_W + IDX_W]));
      end
   endgenerate

   assign set_vec = {(|core_set), port_set};

   fdm_fault_reg #(
      .NUM_ENT (NUM_ENT),
      .IDX_W   (IDX_W)
   ) i_freg (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr_flt),
      .set_i    (set_vec),
      .status_o (fault_status)
   );
endmodule

// File: tb/test_fdm_crc_fault_monitor.sv
module test_fdm_crc_fault_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_flt = 1'b0;
   logic [2:0]  vld = '0, hd = '0, tl = '0;
   logic [47:0] dat = '0;
   logic [5:0]  cmp = '0;
   logic [2:0]  err;
   logic [11:0] stat;

   int checks = 0, fails = 0;
   logic [3:0] unsafe_m = '0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fdm_crc_fault_monitor i_fdm_crc_fault_monitor (
      .clk(clk), .rst_n(rst_n), .clr_flt(clr_flt),
      .flit_valid(vld), .flit_head(hd), .flit_tail(tl),
      .flit_data(dat), .comp_id(cmp),
      .err_pulse(err), .fault_status(stat)
   );

   function automatic logic [3:0] ref_crc(input logic [11:0] m);
      logic [3:0] r = '0;
      logic fb;
      for (int i = 11; i >= 0; i--) begin
         fb = r[3] ^ m[i];
         r  = {r[2:0], 1'b0};
         if (fb) r = r ^ 4'b0011;
      end
      return r;
   endfunction

   function automatic logic [11:0] exp_stat();
      logic [11:0] s;
      for (int e = 0; e < 4; e++) s[e*3 +: 3] = {unsafe_m[e], 2'(e)};
      return s;
   endfunction

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      vld = '0; hd = '0; tl = '0; dat = '0; cmp = '0; clr_flt = 1'b0;
   endtask

   // port, head, tail, comp, payload, crc xor mask, expected pulse
   localparam logic [22:0] VEC [0:7] = '{
      {2'd0, 1'b1, 1'b1, 2'd0, 12'hA5C, 4'h0, 1'b0},  // R2 good single-flit
      {2'd1, 1'b1, 1'b0, 2'd0, 12'h123, 4'h0, 1'b0},  // R4 opens packet
      {2'd1, 1'b0, 1'b0, 2'd0, 12'h777, 4'hF, 1'b0},  // R3 body ignored
      {2'd1, 1'b0, 1'b1, 2'd0, 12'h0F0, 4'h3, 1'b0},  // R3 tail ignored
      {2'd2, 1'b1, 1'b1, 2'd0, 12'hFFF, 4'h1, 1'b1},  // R1 R6 link fault south
      {2'd0, 1'b1, 1'b1, 2'd1, 12'h000, 4'h8, 1'b1},  // R1 R6 buffer fault router
      {2'd1, 1'b1, 1'b0, 2'd0, 12'h9A3, 4'h0, 1'b0},  // R4 opens packet
      {2'd1, 1'b1, 1'b1, 2'd0, 12'h456, 4'h0, 1'b1}   // R4 framing fault north
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 err", {9'd0, err}, 12'h0);
      chk("R10 R5 status", stat, 12'h688);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         int p;
         logic [22:0] e;
         e = VEC[v];
         p = int'(e[22:21]);
         idle_inputs();
         vld[p] = 1'b1; hd[p] = e[20]; tl[p] = e[19];
         cmp[p*2 +: 2] = e[18:17];
         dat[p*16 +: 16] = {e[16:5], ref_crc(e[16:5]) ^ e[4:1]};
         if (e[0]) begin
            if (e[18:17] == 2'd0) unsafe_m[p] = 1'b1;
            else                  unsafe_m[3] = 1'b1;
         end
         @(negedge clk);
         idle_inputs();
         chk("R1 R2 R3 R4 pulse", {9'd0, err}, {9'd0, (3'(e[0]) << p)});
         chk("R6 R8 status", stat, exp_stat());
      end

      // R1 pulse lasts one cycle only
      @(negedge clk);
      chk("R1 pulse width", {9'd0, err}, 12'h0);
      chk("R7 sticky", stat, 12'hFA8);

      // R7 clear
      clr_flt = 1'b1;
      @(negedge clk);
      idle_inputs();
      unsafe_m = '0;
      chk("R7 clear", stat, 12'h688);

      // R7 set wins over clear on the same edge
      clr_flt = 1'b1;
      vld[0] = 1'b1; hd[0] = 1'b1; tl[0] = 1'b1;
      dat[15:0] = {12'h3C3, ref_crc(12'h3C3) ^ 4'h4};
      unsafe_m[0] = 1'b1;
      @(negedge clk);
      idle_inputs();
      chk("R7 set over clear pulse", {9'd0, err}, 12'h001);
      chk("R7 set over clear status", stat, exp_stat());

      // R7 R2 good traffic leaves fault in place
      vld = 3'b111; hd = 3'b111; tl = 3'b111;
      for (int q = 0; q < 3; q++) dat[q*16 +: 16] = {12'(q*12'h111 + 12'h05A), ref_crc(12'(q*12'h111 + 12'h05A))};
      @(negedge clk);
      idle_inputs();
      chk("R2 good on all ports", {9'd0, err}, 12'h0);
      chk("R7 sticky after good", stat, exp_stat());

      // R9 simultaneous faults: port1 crossbar, port2 link
      vld = 3'b110; hd = 3'b110; tl = 3'b110;
      dat[31:16] = {12'hBEE, ref_crc(12'hBEE) ^ 4'h2};
      dat[47:32] = {12'h0C1, ref_crc(12'h0C1) ^ 4'h5};
      cmp = {2'd0, 2'd2, 2'd0};
      unsafe_m[3] = 1'b1; unsafe_m[2] = 1'b1;
      @(negedge clk);
      idle_inputs();
      chk("R9 pulses", {9'd0, err}, 12'h006);
      chk("R9 R6 status", stat, exp_stat());
      chk("R6 north untouched", {11'd0, stat[5]}, 12'h0);

      // R10 reset mid-operation
      rst_n = 1'b0;
      @(negedge clk);
      unsafe_m = '0;
      chk("R10 reset clears", stat, 12'h688);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 no packet left open: a header after reset is not framing
      vld[1] = 1'b1; hd[1] = 1'b1; tl[1] = 1'b1;
      dat[31:16] = {12'h5A5, ref_crc(12'h5A5)};
      @(negedge clk);
      idle_inputs();
      chk("R10 R4 no open packet", {9'd0, err}, 12'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule